// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block connects two 18-bit buses, called A and B, through registers in both directions. Each direction has its own clocking, an active-low clock enable and an active-low output enable. Traffic from A to B is captured in one register on the rising edge of a dedicated clock. Traffic from B to A has two routes, and a bypass input picks between them. The first route is a four-register pipeline. The second is a single register.

The B-to-A direction uses two clocks. The first clock shifts B data through three pipeline stages. The second clock loads the A-side output register. That register takes its input from the last pipeline stage when the bypass input is low. When the bypass input is high, it takes its input directly from the B inputs. The pipeline stages keep advancing on the first clock whatever the bypass setting is.

Tri-state buses are modelled as a data port plus a drive-enable port. The drive enables follow only the output-enable inputs. A single active-low reset is sampled on the rising edge of each clock. It clears the registers that clock owns.

Top module: `reg_bus_xcvr`

## Requirements
- R1: With `rst_n` low at a rising edge of a clock, every register owned by that clock becomes zero. After reset, `a_out` and `b_out` read 0.
- R2: At a rising edge of `clk_ab` with `ab_ce_n` low, the A-to-B register captures `a_in`, and `b_out` shows that value from that edge on.
- R3: At a rising edge of `clk_ab` with `ab_ce_n` high, `b_out` keeps its previous value whatever `a_in` is.
- R4: `b_drv` is 1 (B bus driven) exactly when `ab_oe_n` is 0. When `b_drv` is 0 the B bus is high-impedance, and the stored A-to-B value is unaffected.
- R5: `a_drv` is 1 (A bus driven) exactly when `ba_oe_n` is 0. When `a_drv` is 0 the A bus is high-impedance, and the stored B-to-A value is unaffected.
- R6: With `bypass` = 0, a `b_in` value reaches `a_out` after three rising edges of `clk_ba1` followed by one rising edge of `clk_ba2`. When both clocks share one clock, that is a latency of four edges.
- R7: With `bypass` = 1 at a rising edge of `clk_ba2` and `ba_ce_n` low, `a_out` loads `b_in` directly through one register.
- R8: With `ba_ce_n` high, edges of `clk_ba1` and `clk_ba2` change neither the pipeline stages nor `a_out`.
- R9: Edges of `clk_ba1` alone never change `a_out`. An edge of `clk_ba2` alone with `bypass` = 0 copies only the third stage into `a_out`.
- R10: The `bypass` level at each `clk_ba2` edge picks the source of that load only. Switching `bypass` does not disturb the data held in the pipeline.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ab | input | 1 | A-to-B capture clock |
| clk_ba1 | input | 1 | B-to-A pipeline stage clock |
| clk_ba2 | input | 1 | B-to-A output register clock |
| rst_n | input | 1 | Active-low reset, synchronous to each clock |
| ab_ce_n | input | 1 | Active-low A-to-B clock enable |
| ba_ce_n | input | 1 | Active-low B-to-A clock enable (all B-to-A registers) |
| ab_oe_n | input | 1 | Active-low B bus output enable |
| ba_oe_n | input | 1 | Active-low A bus output enable |
| bypass | input | 1 | 1 selects the single-register B-to-A route, 0 the pipeline |
| a_in | input | 18 | Data sampled from the A bus |
| b_in | input | 18 | Data sampled from the B bus |
| a_out | output | 18 | Data driven onto the A bus |
| a_drv | output | 1 | A bus drive enable (0 = high-impedance) |
| b_out | output | 18 | Data driven onto the B bus |
| b_drv | output | 1 | B bus drive enable (0 = high-impedance) |

## Verification
A pipeline stage that is lost, duplicated or wrongly enabled shows up at `a_out` as a value arriving one `clk_ba1` edge early or late. It appears at the first `clk_ba2` edge that follows with `bypass` low. While `bypass` stays high, such a stage error can stay hidden for many cycles, because the faulty stages are never read. For that reason the bench returns to the pipeline route right after each stretch on the bypass route. A stuck or wrongly gated A-to-B register shows at `b_out` one `clk_ab` edge after the stimulus. A wrong drive enable shows at once on `a_drv` or `b_drv`.

// File: rtl/xcvr_pkg.sv
// Shared constants for the registered bus transceiver.
// Assumes: consumers take the default width from here and can override it by parameter.
package xcvr_pkg;
    localparam int XCVR_WIDTH_DEF = 18;
    localparam int XCVR_STAGES_DEF = 3;
endpackage

// File: rtl/ab_capture_reg.sv
// A-to-B capture register: one enabled register on its own clock.
// Assumes: rst_n is synchronous to clk, and ce_n is active low.
module ab_capture_reg #(
    parameter int W = xcvr_pkg::XCVR_WIDTH_DEF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ce_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    // Capture d when enabled; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (!ce_n)
            q <= d;
    end

    // R1
    ab_reset_clear_chk: assert property (@(posedge clk) !rst_n |=> q == '0);

    // R2
    ab_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_n |=> q == $past(d));

    // R3
    ab_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> $stable(q));

endmodule

// File: rtl/ba_stage_chain.sv
// B-to-A pipeline stages: STAGES registers in series on the first B-to-A clock.
// Assumes: a single shared active-low enable gates every stage, and rst_n is synchronous.
module ba_stage_chain #(
    parameter int W      = xcvr_pkg::XCVR_WIDTH_DEF,
    parameter int STAGES = xcvr_pkg::XCVR_STAGES_DEF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ce_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    localparam int LAST = STAGES - 1;

    logic [W-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_head
            // Head stage samples the B inputs.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    stg[0] <= '0;
                else if (!ce_n)
                    stg[0] <= d;
            end
        end else begin : g_body
            // Later stages shift from their predecessor.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    stg[g] <= '0;
                else if (!ce_n)
                    stg[g] <= stg[g-1];
            end

            // R6
            stage_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !ce_n |=> stg[g] == $past(stg[g-1]));

            // R8
            stage_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ce_n |=> $stable(stg[g]));
        end
    end

    assign q = stg[LAST];

endmodule

// File: rtl/ba_out_reg.sv
// B-to-A output register on the second B-to-A clock, with a source select.
// Assumes: bypass = 1 takes the B inputs directly; bypass = 0 takes the last pipeline stage.
module ba_out_reg #(
    parameter int W = xcvr_pkg::XCVR_WIDTH_DEF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ce_n,
    input  logic         bypass,
    input  logic [W-1:0] from_pipe,
    input  logic [W-1:0] from_bus,
    output logic [W-1:0] q
);

    logic [W-1:0] src;

    // Pick the load source for the next edge.
    always_comb src = bypass ? from_bus : from_pipe;

    // Load the selected source when enabled; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (!ce_n)
            q <= src;
    end

    // R1
    ba_reset_clear_chk: assert property (@(posedge clk) !rst_n |=> q == '0);

    // R6
    ba_pipe_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !bypass) |=> q == $past(from_pipe));

    // R7
    ba_bypass_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && bypass) |=> q == $past(from_bus));

    // R8
    ba_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> $stable(q));

endmodule

// File: rtl/bus_drive.sv
// Tri-state control for one bus side: turns an active-low output enable into a drive enable.
// Assumes: the bus data comes straight from the owning register and the enable is asynchronous.
module bus_drive #(
    parameter int W = xcvr_pkg::XCVR_WIDTH_DEF
) (
    input  logic         oe_n,
    input  logic [W-1:0] held,
    output logic [W-1:0] data,
    output logic         drv
);

    // Present the held value and decode the enable.
    always_comb begin
        data = held;
        drv  = ~oe_n;
    end

endmodule

// File: rtl/reg_bus_xcvr.sv
// Registered bidirectional bus transceiver, top level.
// A-to-B goes through one register. B-to-A goes through a selectable pipeline
// (STAGES stages on clk_ba1 plus the output register on clk_ba2) or through the output register alone.
// Assumes: rst_n is held low across at least one rising edge of every clock.
module reg_bus_xcvr #(
    parameter int W      = xcvr_pkg::XCVR_WIDTH_DEF,
    parameter int STAGES = xcvr_pkg::XCVR_STAGES_DEF
) (
    input  logic         clk_ab,
    input  logic         clk_ba1,
    input  logic         clk_ba2,
    input  logic         rst_n,
    input  logic         ab_ce_n,
    input  logic         ba_ce_n,
    input  logic         ab_oe_n,
    input  logic         ba_oe_n,
    input  logic         bypass,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] a_out,
    output logic         a_drv,
    output logic [W-1:0] b_out,
    output logic         b_drv
);

    logic [W-1:0] ab_q;
    logic [W-1:0] pipe_tail;
    logic [W-1:0] ba_q;

    ab_capture_reg #(.W(W)) u_ab (
        .clk   (clk_ab),
        .rst_n (rst_n),
        .ce_n  (ab_ce_n),
        .d     (a_in),
        .q     (ab_q)
    );

    ba_stage_chain #(.W(W), .STAGES(STAGES)) u_chain (
        .clk   (clk_ba1),
        .rst_n (rst_n),
        .ce_n  (ba_ce_n),
        .d     (b_in),
        .q     (pipe_tail)
    );

    ba_out_reg #(.W(W)) u_ba_out (
        .clk       (clk_ba2),
        .rst_n     (rst_n),
        .ce_n      (ba_ce_n),
        .bypass    (bypass),
        .from_pipe (pipe_tail),
        .from_bus  (b_in),
        .q         (ba_q)
    );

    bus_drive #(.W(W)) u_drv_b (
        .oe_n (ab_oe_n),
        .held (ab_q),
        .data (b_out),
        .drv  (b_drv)
    );

    bus_drive #(.W(W)) u_drv_a (
        .oe_n (ba_oe_n),
        .held (ba_q),
        .data (a_out),
        .drv  (a_drv)
    );

    // R4
    b_oe_hold_chk: assert property (@(posedge clk_ab) disable iff (!rst_n)
        (ab_ce_n && $rose(ab_oe_n)) |=> $stable(b_out));

    // R5
    a_oe_hold_chk: assert property (@(posedge clk_ba2) disable iff (!rst_n)
        (ba_ce_n && $rose(ba_oe_n)) |=> $stable(a_out));

endmodule

// File: tb/tb_reg_bus_xcvr.sv
module tb_reg_bus_xcvr;

    localparam int W = 18;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic manual = 1'b0;
    logic m1 = 1'b0;
    logic m2 = 1'b0;
    logic clk_ba1, clk_ba2;
    assign clk_ba1 = manual ? m1 : clk;
    assign clk_ba2 = manual ? m2 : clk;

    logic rst_n = 1'b0;
    logic ab_ce_n = 1'b1, ba_ce_n = 1'b1, ab_oe_n = 1'b0, ba_oe_n = 1'b0, bypass = 1'b0;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic [W-1:0] a_out, b_out;
    logic a_drv, b_drv;

    reg_bus_xcvr dut (
        .clk_ab  (clk),
        .clk_ba1 (clk_ba1),
        .clk_ba2 (clk_ba2),
        .rst_n   (rst_n),
        .ab_ce_n (ab_ce_n),
        .ba_ce_n (ba_ce_n),
        .ab_oe_n (ab_oe_n),
        .ba_oe_n (ba_oe_n),
        .bypass  (bypass),
        .a_in    (a_in),
        .b_in    (b_in),
        .a_out   (a_out),
        .a_drv   (a_drv),
        .b_out   (b_out),
        .b_drv   (b_drv)
    );

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%05h expected=%05h", req, act, exp);
        end
    endtask

    task automatic pulse1();
        #3 m1 = 1'b1;
        #3 m1 = 1'b0;
        #3;
    endtask

    task automatic pulse2();
        #3 m2 = 1'b1;
        #3 m2 = 1'b0;
        #3;
    endtask

    typedef struct packed {
        logic         ab_ce_n;
        logic         ba_ce_n;
        logic         bypass;
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic [W-1:0] exp_b;
        logic [W-1:0] exp_a;
    } vec_t;

    // All clocks shared: one edge per vector, checked after that edge.
    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b0, 1'b0, 18'h00011, 18'h00101, 18'h00011, 18'h00000},
        '{1'b0, 1'b0, 1'b0, 18'h00022, 18'h00202, 18'h00022, 18'h00000},
        '{1'b0, 1'b0, 1'b0, 18'h00033, 18'h00303, 18'h00033, 18'h00000},
        '{1'b0, 1'b0, 1'b0, 18'h00044, 18'h00404, 18'h00044, 18'h00101},
        '{1'b1, 1'b0, 1'b0, 18'h00055, 18'h00505, 18'h00044, 18'h00202},
        '{1'b0, 1'b1, 1'b0, 18'h00066, 18'h00606, 18'h00066, 18'h00202},
        '{1'b0, 1'b1, 1'b1, 18'h00077, 18'h00707, 18'h00077, 18'h00202},
        '{1'b0, 1'b0, 1'b1, 18'h3FFFF, 18'h2AAAA, 18'h3FFFF, 18'h2AAAA},
        '{1'b0, 1'b0, 1'b0, 18'h00000, 18'h15555, 18'h00000, 18'h00404},
        '{1'b0, 1'b0, 1'b1, 18'h12345, 18'h0BEEF, 18'h12345, 18'h0BEEF},
        '{1'b0, 1'b0, 1'b0, 18'h00001, 18'h00000, 18'h00001, 18'h2AAAA},
        '{1'b1, 1'b0, 1'b0, 18'h3FFFF, 18'h00000, 18'h00001, 18'h15555}
    };

    initial begin
        #1_000_000;
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // Reset with all clocks running. R1
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset a_out", a_out, '0);
        check("R1 reset b_out", b_out, '0);
        check("R4 b_drv on", {17'b0, b_drv}, 18'd1);
        check("R5 a_drv on", {17'b0, a_drv}, 18'd1);

        // Vector walk: R2 R3 R6 R7 R8 R10 with shared clocks.
        for (int i = 0; i <= NV; i++) begin
            @(negedge clk);
            if (i > 0) begin
                check("R2/R3 vec b_out", b_out, VEC[i-1].exp_b);
                check("R6/R7/R8 vec a_out", a_out, VEC[i-1].exp_a);
            end
            if (i < NV) begin
                ab_ce_n = VEC[i].ab_ce_n;
                ba_ce_n = VEC[i].ba_ce_n;
                bypass  = VEC[i].bypass;
                a_in    = VEC[i].a;
                b_in    = VEC[i].b;
            end
        end
        // Freeze, then take manual control of the B-to-A clocks.
        // Stages now: s1=0, s2=0, s3=0BEEF; a_out=15555.
        ab_ce_n = 1'b1;
        ba_ce_n = 1'b1;
        manual  = 1'b1;

        // Output enables: drive flags follow the pins, data held. R4 R5
        ab_oe_n = 1'b1;
        ba_oe_n = 1'b1;
        #1;
        check("R4 b_drv off", {17'b0, b_drv}, '0);
        check("R5 a_drv off", {17'b0, a_drv}, '0);
        check("R4 b_out kept while off", b_out, 18'h00001);
        check("R5 a_out kept while off", a_out, 18'h15555);
        ab_oe_n = 1'b0;
        ba_oe_n = 1'b0;
        #1;
        check("R4 b_drv back", {17'b0, b_drv}, 18'd1);
        check("R5 a_drv back", {17'b0, a_drv}, 18'd1);

        // Separate clocks: three clk_ba1 edges then one clk_ba2 edge. R6 R9
        ba_ce_n = 1'b0;
        bypass  = 1'b0;
        b_in    = 18'h0AAAA;
        pulse1();
        check("R9 clk_ba1 alone no change", a_out, 18'h15555);
        b_in = '0;
        pulse1();
        pulse1();
        check("R9 after three clk_ba1", a_out, 18'h15555);
        pulse2();
        check("R6 arrives after clk_ba2", a_out, 18'h0AAAA);
        pulse2();
        check("R9 clk_ba2 alone copies stage three", a_out, 18'h0AAAA);

        // Bypass load, then back to pipeline: stage contents undisturbed. R7 R10
        b_in   = 18'h31313;
        bypass = 1'b1;
        pulse2();
        check("R7 bypass direct load", a_out, 18'h31313);
        bypass = 1'b0;
        pulse2();
        check("R10 pipeline kept across bypass", a_out, 18'h0AAAA);

        // Disabled clock enable freezes stages and output. R8
        ba_ce_n = 1'b1;
        bypass  = 1'b1;
        b_in    = 18'h00F0F;
        pulse2();
        check("R8 output held", a_out, 18'h0AAAA);
        pulse1();
        pulse1();
        pulse1();
        ba_ce_n = 1'b0;
        bypass  = 1'b0;
        pulse2();
        check("R8 stages held", a_out, 18'h0AAAA);

        // Reset in manual mode clears every register. R1
        rst_n = 1'b0;
        pulse1();
        pulse2();
        @(negedge clk);
        @(negedge clk);
        check("R1 a_out cleared", a_out, '0);
        check("R1 b_out cleared", b_out, '0);
        rst_n  = 1'b1;
        b_in   = 18'h00001;
        bypass = 1'b1;
        pulse2();
        check("R7 load after reset", a_out, 18'h00001);
        bypass = 1'b0;
        pulse2();
        check("R1 stage three cleared", a_out, '0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule